// File: doc/BRIEF.md
# Single-Channel Validated Block Mover

This block is one DMA channel that copies a block of 32-bit words from system memory to one of two destination targets. Software fills a small register bank (source, destination, transfer count, channel control, a global operation word and a length), then writes the go register. The channel accepts the request only if the masked global word matches one exact pattern and the length is a whole number of 32-byte units. A refused request leaves every register as it was and reports a one-cycle error.

An accepted request is steered by the destination address. One window feeds a streaming port that takes 32-byte blocks at a fixed address. A second window is remapped into a linear memory region and written word by word at rising addresses. Any other destination moves no data. Source reads wrap at the end of system RAM, which splits the read into a second segment. When the transfer is over, the channel writes the final source address back, clears its enable bit, count and length, and pulses a completion interrupt.

Top module: `chan_dma`

## Requirements
- R1: After reset, busy, err and irq are low and the control (0x0C), global (0x40), go (0x44) and length (0x48) registers read zero.
- R2: Registers sit at byte offsets source 0x00, destination 0x04, count 0x08, control 0x0C, global 0x40, go 0x44, length 0x48. Each written value reads back unchanged while the channel is idle. Go reads bit 0 = busy, and a go request is a write to 0x44 with bit 0 set.
- R3: A go request is refused when (global & 0x00008307) != 0x00008201. err is then high for exactly the next cycle, busy stays low, no read or write is issued, no irq follows and all registers keep their values.
- R4: A go request is refused in the same way when any of bits 4..0 of the length register is set.
- R5: A destination in 0x10000000..0x10FFFFFF writes length/4 words with wr_stream=1 and wr_addr equal to the destination register on every word. wr_blk_end is high on every 8th word, which closes a 32-byte block.
- R6: A destination in 0x11000000..0x11FFFFE0 writes length/4 words with wr_stream=0. Word k goes to ((dst & 0x00FFFFFF) | 0xA4000000) + 4k.
- R7: Any other destination, including 0x13000000..0x13FFFFE0 and 0x11FFFFE4..0x11FFFFFF, issues no read and no write. It still completes as in R10.
- R8: Read k is issued at {src[31:24], (src[23:0] + 4k) mod 2^24}. A span that crosses the end of the 16 MiB RAM therefore continues from the RAM base as a second segment.
- R9: The data of write k equals the data returned for read k, in order.
- R10: At completion the source reads start source + length, control bit 0 is cleared with the other control bits kept, count and length read 0, go reads 0, the destination is unchanged, and irq is high for one cycle, the cycle busy first reads low.
- R11: busy is high from the cycle after an accepted go until the irq cycle. While busy, writes to any register, go included, are ignored.
- R12: rd_valid/wr_valid hold their address and data stable until the matching ready. With both readies held high, a transfer of N words keeps busy high for exactly N+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted, rd_data valid |
| rd_addr | output | 32 | Read word address |
| rd_data | input | 32 | Read data, same cycle as handshake |
| wr_valid | output | 1 | Write valid |
| wr_ready | input | 1 | Write accepted |
| wr_addr | output | 32 | Write address |
| wr_data | output | 32 | Write data |
| wr_stream | output | 1 | Write targets the streaming port |
| wr_blk_end | output | 1 | Last word of a 32-byte block |
| busy | output | 1 | Transfer in progress |
| err | output | 1 | One-cycle pulse on a refused go |
| irq | output | 1 | One-cycle completion pulse |

## Verification
A wrong word counter or route decision shows up at the write port within one handshake. Either a write arrives that the reference did not expect, or the address or stream flag is wrong, or busy fails to drop the cycle after the last expected write. A corrupt RAM offset shows on the read address at the wrap point. A bad write-back shows in the first register read after irq. A faulty validation shows as a busy or err mismatch in the cycle right after the go write.

// File: rtl/chan_dma_pkg.sv
// Shared definitions for the single-channel block mover: route kinds and
// register byte offsets. Offsets are fixed by the software view.
package chan_dma_pkg;

    typedef enum logic [1:0] {
        RT_STREAM = 2'd0,
        RT_LINEAR = 2'd1,
        RT_DROP   = 2'd2
    } route_e;

    localparam int REG_AW = 8;

    localparam logic [REG_AW-1:0] OFS_SRC  = 8'h00;
    localparam logic [REG_AW-1:0] OFS_DST  = 8'h04;
    localparam logic [REG_AW-1:0] OFS_CNT  = 8'h08;
    localparam logic [REG_AW-1:0] OFS_CTRL = 8'h0C;
    localparam logic [REG_AW-1:0] OFS_GLB  = 8'h40;
    localparam logic [REG_AW-1:0] OFS_GO   = 8'h44;
    localparam logic [REG_AW-1:0] OFS_LEN  = 8'h48;

endpackage

// File: rtl/chan_dma_regs.sv
// Register bank of the channel.
// Holds source, destination, count, control, global and length words.
// Assumes: writes are ignored while busy; done arrives only while busy and
// carries the final source address. Source, destination and count have no
// reset value; control, global and length clear on reset.
module chan_dma_regs
    import chan_dma_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_AW-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic              busy,
    input  logic              done,
    input  logic [DW-1:0]     done_src,
    output logic [DW-1:0]     src,
    output logic [DW-1:0]     dst,
    output logic [DW-1:0]     glb,
    output logic [DW-1:0]     len,
    output logic [DW-1:0]     rdata,
    output logic              start_req
);

    logic [DW-1:0] cnt_q;
    logic [DW-1:0] ctrl_q;
    logic          wr_ok;

    assign wr_ok     = we && !busy;
    assign start_req = wr_ok && (addr == OFS_GO) && wdata[0];

    // Reset-cleared registers: control, global, length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            glb    <= '0;
            len    <= '0;
        end else if (done) begin
            ctrl_q[0] <= 1'b0;
            len       <= '0;
        end else if (wr_ok) begin
            case (addr)
                OFS_CTRL: ctrl_q <= wdata;
                OFS_GLB:  glb    <= wdata;
                OFS_LEN:  len    <= wdata;
                default:  ;
            endcase
        end
    end

    // Registers that keep their value across reset: source, destination, count.
    always_ff @(posedge clk) begin
        if (done) begin
            src   <= done_src;
            cnt_q <= '0;
        end else if (wr_ok) begin
            case (addr)
                OFS_SRC: src   <= wdata;
                OFS_DST: dst   <= wdata;
                OFS_CNT: cnt_q <= wdata;
                default: ;
            endcase
        end
    end

    // Read-back multiplexer.
    always_comb begin
        case (addr)
            OFS_SRC:  rdata = src;
            OFS_DST:  rdata = dst;
            OFS_CNT:  rdata = cnt_q;
            OFS_CTRL: rdata = ctrl_q;
            OFS_GLB:  rdata = glb;
            OFS_GO:   rdata = {{(DW-1){1'b0}}, busy};
            OFS_LEN:  rdata = len;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/chan_dma_route.sv
// Destination decoder.
// Picks the route from the destination address and produces the first
// write address. The linear window keeps the low KEEP_BITS bits and ORs in
// REMAP_OR. Purely combinational.
module chan_dma_route
    import chan_dma_pkg::*;
#(
    parameter int          AW        = 32,
    parameter logic [31:0] STR_LO    = 32'h1000_0000,
    parameter logic [31:0] STR_HI    = 32'h10FF_FFFF,
    parameter logic [31:0] LIN_LO    = 32'h1100_0000,
    parameter logic [31:0] LIN_HI    = 32'h11FF_FFE0,
    parameter int          KEEP_BITS = 24,
    parameter logic [31:0] REMAP_OR  = 32'hA400_0000
) (
    input  logic [AW-1:0] dst,
    output route_e        route,
    output logic [AW-1:0] wbase
);

    localparam logic [AW-1:0] KEEP_MASK = AW'((64'd1 << KEEP_BITS) - 64'd1);

    // Window compare and remap.
    always_comb begin
        if (dst >= AW'(STR_LO) && dst <= AW'(STR_HI)) begin
            route = RT_STREAM;
            wbase = dst;
        end else if (dst >= AW'(LIN_LO) && dst <= AW'(LIN_HI)) begin
            route = RT_LINEAR;
            wbase = (dst & KEEP_MASK) | AW'(REMAP_OR);
        end else begin
            route = RT_DROP;
            wbase = dst;
        end
    end

endmodule

// File: rtl/chan_dma_mover.sv
// Word mover.
// After start it reads len/DW-bytes words from a RAM-wrapped source and
// writes them to the chosen target through a one-word buffer. Both sides
// use valid/ready. The buffer refills in the cycle it drains, so one word
// moves per cycle. Assumes start is only raised while idle and that
// BLK_WORDS is a power of two.
module chan_dma_mover
    import chan_dma_pkg::*;
#(
    parameter int DW        = 32,
    parameter int AW        = 32,
    parameter int RAM_AW    = 24,
    parameter int BLK_WORDS = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] wbase,
    input  route_e        route,
    input  logic [AW-1:0] len,
    output logic          rd_valid,
    input  logic          rd_ready,
    output logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] rd_data,
    output logic          wr_valid,
    input  logic          wr_ready,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          wr_stream,
    output logic          wr_blk_end,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] end_src
);

    localparam int WB  = DW / 8;
    localparam int WSH = $clog2(WB);
    localparam int BW  = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1;
    localparam logic [BW-1:0] BLK_LAST = BW'(BLK_WORDS - 1);

    logic [AW-1:0]        rd_left;
    logic [AW-1:0]        wr_left;
    logic [RAM_AW-1:0]    rd_off;
    logic [AW-RAM_AW-1:0] rd_hi;
    logic [BW-1:0]        blk_cnt;
    logic                 buf_full;
    logic [DW-1:0]        buf_q;
    logic [AW-1:0]        words;
    logic                 rd_fire;
    logic                 wr_fire;

    assign words    = (route == RT_DROP) ? '0 : (len >> WSH);
    assign wr_valid = buf_full;
    assign wr_fire  = wr_valid && wr_ready;
    assign rd_valid = busy && (rd_left != '0) && (!buf_full || wr_fire);
    assign rd_fire  = rd_valid && rd_ready;
    assign rd_addr  = {rd_hi, rd_off};
    assign wr_data  = buf_q;
    assign wr_blk_end = wr_valid && wr_stream && (blk_cnt == BLK_LAST);
    assign done     = busy && ((wr_left == '0) || ((wr_left == AW'(1)) && wr_fire));

    // Transfer state: load on start, advance on handshakes, stop on done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            rd_left   <= '0;
            wr_left   <= '0;
            rd_off    <= '0;
            rd_hi     <= '0;
            blk_cnt   <= '0;
            buf_full  <= 1'b0;
            buf_q     <= '0;
            wr_addr   <= '0;
            wr_stream <= 1'b0;
            end_src   <= '0;
        end else if (start) begin
            busy      <= 1'b1;
            rd_left   <= words;
            wr_left   <= words;
            rd_off    <= src[RAM_AW-1:0];
            rd_hi     <= src[AW-1:RAM_AW];
            blk_cnt   <= '0;
            buf_full  <= 1'b0;
            wr_addr   <= wbase;
            wr_stream <= (route == RT_STREAM);
            end_src   <= src + len;
        end else if (busy) begin
            if (done) begin
                busy <= 1'b0;
            end
            if (rd_fire) begin
                rd_left <= rd_left - AW'(1);
                rd_off  <= rd_off + RAM_AW'(WB);
                buf_q   <= rd_data;
            end
            buf_full <= rd_fire || (buf_full && !wr_fire);
            if (wr_fire) begin
                wr_left <= wr_left - AW'(1);
                blk_cnt <= blk_cnt + BW'(1);
                if (!wr_stream) begin
                    wr_addr <= wr_addr + AW'(WB);
                end
            end
        end
    end

endmodule

// File: rtl/chan_dma.sv
// Top of the single-channel block mover.
// Validates a go request against the masked global word and the length
// granule, routes by destination window, runs the word mover and writes
// back the channel registers on completion. err and irq are registered
// one-cycle pulses.
module chan_dma
    import chan_dma_pkg::*;
#(
    parameter int          RAM_AW    = 24,
    parameter int          BLK_WORDS = 8,
    parameter logic [31:0] GLB_MASK  = 32'h0000_8307,
    parameter logic [31:0] GLB_MATCH = 32'h0000_8201
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        rd_valid,
    input  logic        rd_ready,
    output logic [31:0] rd_addr,
    input  logic [31:0] rd_data,
    output logic        wr_valid,
    input  logic        wr_ready,
    output logic [31:0] wr_addr,
    output logic [31:0] wr_data,
    output logic        wr_stream,
    output logic        wr_blk_end,
    output logic        busy,
    output logic        err,
    output logic        irq
);

    localparam int DW   = 32;
    localparam int AW   = 32;
    localparam int LOWB = $clog2(BLK_WORDS * (DW / 8));

    logic [AW-1:0] src;
    logic [AW-1:0] dst;
    logic [AW-1:0] glb;
    logic [AW-1:0] len;
    logic [AW-1:0] wbase;
    logic [AW-1:0] end_src;
    logic          start_req;
    logic          accept;
    logic          done;
    logic          glb_ok;
    logic          len_ok;
    route_e        route;

    assign glb_ok = (glb & GLB_MASK) == GLB_MATCH;
    assign len_ok = (len[LOWB-1:0] == '0);
    assign accept = start_req && glb_ok && len_ok;

    chan_dma_regs #(.DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (reg_we),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .busy      (busy),
        .done      (done),
        .done_src  (end_src),
        .src       (src),
        .dst       (dst),
        .glb       (glb),
        .len       (len),
        .rdata     (reg_rdata),
        .start_req (start_req)
    );

    chan_dma_route #(.AW(AW)) u_route (
        .dst   (dst),
        .route (route),
        .wbase (wbase)
    );

    chan_dma_mover #(
        .DW        (DW),
        .AW        (AW),
        .RAM_AW    (RAM_AW),
        .BLK_WORDS (BLK_WORDS)
    ) u_mover (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (accept),
        .src        (src),
        .wbase      (wbase),
        .route      (route),
        .len        (len),
        .rd_valid   (rd_valid),
        .rd_ready   (rd_ready),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .wr_valid   (wr_valid),
        .wr_ready   (wr_ready),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wr_stream  (wr_stream),
        .wr_blk_end (wr_blk_end),
        .busy       (busy),
        .done       (done),
        .end_src    (end_src)
    );

    // Registered refusal and completion pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err <= 1'b0;
            irq <= 1'b0;
        end else begin
            err <= start_req && !accept;
            irq <= done;
        end
    end

endmodule

// File: rtl/chan_dma_chk.sv
// Protocol checker for chan_dma, attached by bind. Observes ports only.
module chan_dma_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_valid,
    input logic        rd_ready,
    input logic [31:0] rd_addr,
    input logic        wr_valid,
    input logic        wr_ready,
    input logic [31:0] wr_addr,
    input logic [31:0] wr_data,
    input logic        wr_stream,
    input logic        busy,
    input logic        err,
    input logic        irq
);

    // R11
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> irq);

    // R10
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R3
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && !irq));

    // R12
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    // R12
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

    // R7
    move_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid || wr_valid) |-> busy);

    // R5
    stream_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_stream) |-> (wr_addr[31:24] == 8'h10));

endmodule

bind chan_dma chan_dma_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_addr   (rd_addr),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_stream (wr_stream),
    .busy      (busy),
    .err       (err),
    .irq       (irq)
);

// File: tb/chan_dma_test.sv
module chan_dma_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rd_valid, rd_ready = 1'b1;
    logic [31:0] rd_addr, rd_data;
    logic        wr_valid, wr_ready = 1'b1;
    logic [31:0] wr_addr, wr_data;
    logic        wr_stream, wr_blk_end, busy, err, irq;

    always #10 clk = ~clk;

    chan_dma uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_stream(wr_stream), .wr_blk_end(wr_blk_end),
        .busy(busy), .err(err), .irq(irq)
    );

    function automatic logic [31:0] dfun(input logic [31:0] a);
        return {a[15:0], ~a[31:16]} ^ 32'h3C5A_96E1;
    endfunction
    assign rd_data = dfun(rd_addr);

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] d;
        logic        s;
        logic        b;
    } wexp_t;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit mon_on = 0;
    int mode = 0;
    int irq_cnt = 0;
    int err_cnt = 0;
    int bcnt = 0;
    logic [15:0] lfsr = 16'hACE1;

    // reference model state
    logic [31:0] sh_src = '0, sh_dst = '0, sh_cnt = '0, sh_ctrl = '0, sh_glb = '0, sh_len = '0;
    logic exp_busy = 0, exp_irq = 0, exp_err = 0;
    logic [31:0] rq[$];
    wexp_t wq[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // ready patterns
    initial begin
        forever begin
            @(posedge clk);
            #2;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (mode)
                0: begin rd_ready = 1'b1; wr_ready = 1'b1; end
                1: begin rd_ready = lfsr[0]; wr_ready = lfsr[3]; end
                default: begin rd_ready = (lfsr[1:0] == 2'b00); wr_ready = (lfsr[5:4] == 2'b00); end
            endcase
        end
    end

    // cycle-by-cycle reference model and comparison
    always @(negedge clk) begin
        if (mon_on) begin
            logic nb, ni, ne;
            chk(busy == exp_busy, "R11", "busy", 32'(busy), 32'(exp_busy));
            chk(irq == exp_irq, "R10", "irq", 32'(irq), 32'(exp_irq));
            chk(err == exp_err, "R3", "err", 32'(err), 32'(exp_err));
            if (irq) irq_cnt++;
            if (err) err_cnt++;
            if (busy) bcnt++;
            if (rd_valid && rd_ready) begin
                if (rq.size() == 0) chk(0, "R7", "unexpected read", rd_addr, 32'hx);
                else begin
                    logic [31:0] ea;
                    ea = rq.pop_front();
                    chk(rd_addr == ea, "R8", "read address", rd_addr, ea);
                end
            end
            if (wr_valid && wr_ready) begin
                if (wq.size() == 0) chk(0, "R7", "unexpected write", wr_addr, 32'hx);
                else begin
                    wexp_t e;
                    e = wq.pop_front();
                    chk(wr_addr == e.a, e.s ? "R5" : "R6", "write address", wr_addr, e.a);
                    chk(wr_stream == e.s, e.s ? "R5" : "R6", "stream flag", 32'(wr_stream), 32'(e.s));
                    chk(wr_blk_end == e.b, "R5", "block end", 32'(wr_blk_end), 32'(e.b));
                    chk(wr_data == e.d, "R9", "write data", wr_data, e.d);
                end
            end
            nb = exp_busy; ni = 0; ne = 0;
            if (exp_busy) begin
                if (wq.size() == 0 && rq.size() == 0) begin
                    ni = 1; nb = 0;
                    sh_src = sh_src + sh_len;
                    sh_ctrl[0] = 1'b0;
                    sh_cnt = '0;
                    sh_len = '0;
                end
            end else if (reg_we) begin
                case (reg_addr)
                    8'h00: sh_src = reg_wdata;
                    8'h04: sh_dst = reg_wdata;
                    8'h08: sh_cnt = reg_wdata;
                    8'h0C: sh_ctrl = reg_wdata;
                    8'h40: sh_glb = reg_wdata;
                    8'h48: sh_len = reg_wdata;
                    8'h44: if (reg_wdata[0]) begin
                        if ((sh_glb & 32'h0000_8307) == 32'h0000_8201 && sh_len[4:0] == 5'd0) begin
                            int rt;
                            logic [31:0] wb;
                            nb = 1;
                            if (sh_dst >= 32'h1000_0000 && sh_dst <= 32'h10FF_FFFF) begin
                                rt = 0; wb = sh_dst;
                            end else if (sh_dst >= 32'h1100_0000 && sh_dst <= 32'h11FF_FFE0) begin
                                rt = 1; wb = (sh_dst & 32'h00FF_FFFF) | 32'hA400_0000;
                            end else begin
                                rt = 2; wb = sh_dst;
                            end
                            if (rt != 2) begin
                                for (int k = 0; k < int'(sh_len >> 2); k++) begin
                                    logic [31:0] ra;
                                    wexp_t w;
                                    ra = {sh_src[31:24], sh_src[23:0] + 24'(4 * k)};
                                    rq.push_back(ra);
                                    w.a = (rt == 0) ? wb : wb + 32'(4 * k);
                                    w.d = dfun(ra);
                                    w.s = (rt == 0);
                                    w.b = (rt == 0) && ((k % 8) == 7);
                                    wq.push_back(w);
                                end
                            end
                        end else ne = 1;
                    end
                    default: ;
                endcase
            end
            exp_busy = nb; exp_irq = ni; exp_err = ne;
        end
    end

    task automatic wreg(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #2;
        reg_we = 1'b0;
    endtask

    task automatic rchk(input logic [7:0] a, input logic [31:0] e, input string req);
        @(posedge clk); #2;
        reg_addr = a;
        @(negedge clk);
        chk(reg_rdata == e, req, $sformatf("reg %h", a), reg_rdata, e);
    endtask

    task automatic wait_irq(input int prev);
        int n = 0;
        while (irq_cnt == prev && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(irq_cnt == prev + 1, "R10", "irq count", 32'(irq_cnt), 32'(prev + 1));
    endtask

    // program, start, wait, and verify write-back of one accepted transfer
    task automatic xfer(input logic [31:0] s, input logic [31:0] d, input logic [31:0] l,
                        input logic [31:0] c, input string req);
        int prev;
        wreg(8'h00, s); wreg(8'h04, d); wreg(8'h08, 32'h0000_0077);
        wreg(8'h0C, c); wreg(8'h40, 32'h0000_8201); wreg(8'h48, l);
        prev = irq_cnt;
        bcnt = 0;
        wreg(8'h44, 32'h1);
        wait_irq(prev);
        rchk(8'h00, s + l, "R10");
        rchk(8'h04, d, "R10");
        rchk(8'h08, 32'h0, "R10");
        rchk(8'h0C, c & 32'hFFFF_FFFE, "R10");
        rchk(8'h48, 32'h0, "R10");
        rchk(8'h44, 32'h0, "R10");
        chk(wq.size() == 0, req, "pending writes", 32'(wq.size()), 32'h0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        mon_on = 1;
        // R1 reset state
        rchk(8'h0C, 32'h0, "R1");
        rchk(8'h40, 32'h0, "R1");
        rchk(8'h44, 32'h0, "R1");
        rchk(8'h48, 32'h0, "R1");
        // R2 readback
        wreg(8'h00, 32'h0C00_1000); rchk(8'h00, 32'h0C00_1000, "R2");
        wreg(8'h04, 32'h1234_5678); rchk(8'h04, 32'h1234_5678, "R2");
        wreg(8'h08, 32'hDEAD_BEEF); rchk(8'h08, 32'hDEAD_BEEF, "R2");
        wreg(8'h0C, 32'h0000_0101); rchk(8'h0C, 32'h0000_0101, "R2");
        // R3 refused by global word
        wreg(8'h40, 32'h0000_8200); wreg(8'h48, 32'h40);
        wreg(8'h44, 32'h1);
        repeat (3) @(negedge clk);
        chk(err_cnt == 1, "R3", "err pulses", 32'(err_cnt), 32'h1);
        rchk(8'h00, 32'h0C00_1000, "R3");
        rchk(8'h48, 32'h40, "R3");
        rchk(8'h0C, 32'h0000_0101, "R3");
        // masked-out bits do not matter: accepted with extra bits (bits 3,4) set
        // R4 refused by length granule
        wreg(8'h40, 32'h0000_8219); wreg(8'h48, 32'h44);
        wreg(8'h44, 32'h1);
        repeat (3) @(negedge clk);
        chk(err_cnt == 2, "R4", "err pulses", 32'(err_cnt), 32'h2);
        rchk(8'h48, 32'h44, "R4");
        chk(irq_cnt == 0, "R4", "no irq", 32'(irq_cnt), 32'h0);
        // R5 stream, R12 timing with always-ready
        mode = 0;
        xfer(32'h0C00_0100, 32'h1000_2000, 32'h40, 32'h0000_1235, "R5");
        chk(bcnt == 17, "R12", "busy cycles", 32'(bcnt), 32'd17);
        // R6 linear with random readies
        mode = 1;
        xfer(32'h0C12_3400, 32'h1134_5600, 32'h60, 32'h0000_0001, "R6");
        // R8 RAM wrap
        xfer(32'h0CFF_FFF0, 32'h1100_0100, 32'h20, 32'h0000_0003, "R8");
        // R7 dropped destinations
        mode = 0;
        xfer(32'h0C00_0200, 32'h1300_0010, 32'h40, 32'h1, "R7");
        chk(bcnt == 1, "R7", "busy cycles", 32'(bcnt), 32'd1);
        xfer(32'h0C00_0300, 32'h11FF_FFF0, 32'h20, 32'h1, "R7");
        // zero length stream
        xfer(32'h0C00_0400, 32'h1000_0000, 32'h0, 32'h1, "R12");
        chk(bcnt == 1, "R12", "zero-length busy cycles", 32'(bcnt), 32'd1);
        // R11 writes while busy are ignored
        mode = 2;
        begin
            int prev;
            wreg(8'h00, 32'h0C00_0800); wreg(8'h04, 32'h1100_0800);
            wreg(8'h48, 32'h40);
            prev = irq_cnt;
            wreg(8'h44, 32'h1);
            wreg(8'h04, 32'h1000_0000);
            wreg(8'h48, 32'h20);
            wreg(8'h44, 32'h1);
            wait_irq(prev);
            repeat (30) @(negedge clk);
            chk(irq_cnt == prev + 1, "R11", "single irq", 32'(irq_cnt), 32'(prev + 1));
            rchk(8'h04, 32'h1100_0800, "R11");
            rchk(8'h00, 32'h0C00_0840, "R11");
        end
        mode = 0;
        repeat (5) @(negedge clk);
        summary();
    end

endmodule